// File: doc/BRIEF.md
# Pipelined Radix-8 Integer Divider

The block divides an unsigned dividend by an unsigned divisor in a fixed-latency pipeline that accepts a new operation on every clock. Each compute stage works out one quotient digit in base eight, so three quotient bits per stage. For each digit, the stage shifts the next three dividend bits into the partial remainder. It then compares the result against the seven nonzero multiples of the divisor in parallel, takes the largest multiple that still fits, and subtracts it. The seven multiples are formed once at entry from shifts and adds. They travel down the pipeline next to the partial remainder.

A static mode input sets how the compute stages share pipeline registers. In the fused setting, two compute stages sit between registers, and the odd last stage gets a register of its own. In the split setting, every compute stage has its own register. This allows a faster clock at the cost of more latency. An opaque tag travels with each operation. There is no backpressure. A divisor of zero gives a defined result and raises a flag.

Top module: `pipelined_radix8_divider`

## Requirements
- R1: With split_mode low and a nonzero divisor, out_quotient equals dividend / divisor and out_remainder equals dividend % divisor. Both are unsigned and WIDTH bits wide.
- R2: With split_mode high, the results are the same as in R1 for every operand pair.
- R3: With split_mode low, a result appears on the outputs 6 clock edges after the edge that captured the operation. This is ceil(ceil(WIDTH/3)/2) for WIDTH = 32.
- R4: With split_mode high, a result appears 11 clock edges after capture, one edge per digit.
- R5: Back-to-back operations each produce exactly one result, in issue order, and each result carries the tag it was issued with.
- R6: A divisor of zero yields a quotient of all ones, a remainder equal to the dividend, and out_div_by_zero high. The flag is low for every nonzero divisor.
- R7: While rst is high, and on the first cycle after it falls with no new input, out_valid is low, whatever in_valid does during reset.
- R8: split_mode may change only on a cycle when no pipeline register holds a valid operation.
- R9: In every pipeline register that holds a valid operation with a nonzero divisor, the partial remainder is below the divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| split_mode | input | 1 | 0: two digit stages per register, 1: a register after every digit stage |
| in_valid | input | 1 | Operation present on the inputs |
| in_dividend | input | WIDTH | Unsigned dividend |
| in_divisor | input | WIDTH | Unsigned divisor |
| in_tag | input | TAG_W | Opaque tag carried with the operation |
| out_valid | output | 1 | Result present on the outputs |
| out_quotient | output | WIDTH | Quotient |
| out_remainder | output | WIDTH | Remainder |
| out_tag | output | TAG_W | Tag of the finished operation |
| out_div_by_zero | output | 1 | The operation had a zero divisor |

## Verification
Suppose one stage picks a wrong digit or subtracts the wrong multiple. The partial remainder then leaves the range below the divisor in that same register, and the quotient and remainder at the outputs are wrong once the operation reaches the end of the pipeline. A bad mode mux or a missing register shows up as a result that arrives on the wrong cycle, or as a lost or duplicated tag. A stale valid bit shows up as an extra result after a drain. Every error therefore appears at the ports no later than one full pipeline latency after the faulty operation entered.

// File: rtl/pipelined_radix8_divider.sv
module pipelined_radix8_divider #(
  parameter int WIDTH = 32,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             split_mode,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_dividend,
  input  logic [WIDTH-1:0] in_divisor,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_quotient,
  output logic [WIDTH-1:0] out_remainder,
  output logic [TAG_W-1:0] out_tag,
  output logic             out_div_by_zero
);
  localparam int ND = (WIDTH + 2) / 3;
  localparam int EW = 3 * ND;
  localparam int RW = WIDTH + 3;
  localparam int MW = 7 * RW;

  logic [RW-1:0] d1, d2, d4;
  logic [MW-1:0] entry_mult;
  assign d1 = RW'(in_divisor);
  assign d2 = d1 << 1;
  assign d4 = d1 << 2;
  assign entry_mult = {(d1 << 3) - d1, d4 + d2, d4 + d1, d4, d2 + d1, d2, d1};

  logic             c_v   [ND];
  logic             c_dz  [ND];
  logic [TAG_W-1:0] c_tag [ND];
  logic [RW-1:0]    c_rem [ND];
  logic [EW-1:0]    c_qd  [ND];
  logic [MW-1:0]    c_m   [ND];
  logic             r_v   [ND];
  logic             r_dz  [ND];
  logic [TAG_W-1:0] r_tag [ND];
  logic [RW-1:0]    r_rem [ND];
  logic [EW-1:0]    r_qd  [ND];
  logic [MW-1:0]    r_m   [ND];
  logic [ND-1:0]    busy_vec;

  for (genvar i = 0; i < ND; i++) begin : g_st
    logic             s_v, s_dz;
    logic [TAG_W-1:0] s_tag;
    logic [RW-1:0]    s_rem, x, sub;
    logic [EW-1:0]    s_qd;
    logic [MW-1:0]    s_m;
    logic [2:0]       dg;

    if (i == 0) begin : g_entry
      assign s_v   = in_valid;
      assign s_dz  = (in_divisor == '0);
      assign s_tag = in_tag;
      assign s_rem = '0;
      assign s_qd  = EW'(in_dividend);
      assign s_m   = entry_mult;
    end else begin : g_link
      localparam bit ALWAYS_REG = ((i - 1) % 2 == 1) || (i - 1 == ND - 1);
      logic use_reg;
      assign use_reg = ALWAYS_REG || split_mode;
      assign s_v   = use_reg ? r_v[i-1]   : c_v[i-1];
      assign s_dz  = use_reg ? r_dz[i-1]  : c_dz[i-1];
      assign s_tag = use_reg ? r_tag[i-1] : c_tag[i-1];
      assign s_rem = use_reg ? r_rem[i-1] : c_rem[i-1];
      assign s_qd  = use_reg ? r_qd[i-1]  : c_qd[i-1];
      assign s_m   = use_reg ? r_m[i-1]   : c_m[i-1];
    end

    assign x = {s_rem[RW-4:0], s_qd[EW-1 -: 3]};

    always_comb begin
      dg  = '0;
      sub = '0;
      for (int k = 1; k < 8; k++)
        if (x >= s_m[(k-1)*RW +: RW]) begin
          dg  = 3'(k);
          sub = s_m[(k-1)*RW +: RW];
        end
    end

    assign c_v[i]   = s_v;
    assign c_dz[i]  = s_dz;
    assign c_tag[i] = s_tag;
    assign c_rem[i] = x - sub;
    assign c_qd[i]  = {s_qd[EW-4:0], dg};
    assign c_m[i]   = s_m;

    always_ff @(posedge clk) begin
      if (rst) r_v[i] <= 1'b0;
      else     r_v[i] <= c_v[i];
      r_dz[i]  <= c_dz[i];
      r_tag[i] <= c_tag[i];
      r_rem[i] <= c_rem[i];
      r_qd[i]  <= c_qd[i];
      r_m[i]   <= c_m[i];
    end

    assign busy_vec[i] = r_v[i];

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
      (r_v[i] && !r_dz[i]) |-> (r_rem[i] < r_m[i][RW-1:0])) // R9
      else $error("partial remainder out of range in stage %0d", i);
  end

  assign out_valid       = r_v[ND-1];
  assign out_div_by_zero = r_dz[ND-1];
  assign out_tag         = r_tag[ND-1];
  assign out_quotient    = r_qd[ND-1][WIDTH-1:0];
  assign out_remainder   = r_rem[ND-1][WIDTH-1:0];

  AST_MODE_STATIC: assert property (@(posedge clk) disable iff (rst)
    (split_mode != $past(split_mode)) |-> !$past(|busy_vec)) // R8
    else $error("split_mode changed while pipeline busy");

  AST_ZERO_DIVISOR_ONES: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_div_by_zero) |-> (&out_quotient)) // R6
    else $error("zero divisor quotient not all ones");

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> !out_valid) // R7
    else $error("valid output right after reset");
endmodule

// File: tb/tb_pipelined_radix8_divider.sv
module tb_pipelined_radix8_divider;
  localparam int W = 32;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic split_mode = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_dividend = '0, in_divisor = '0;
  logic [TW-1:0] in_tag = '0;
  logic out_valid, out_div_by_zero;
  logic [W-1:0] out_quotient, out_remainder;
  logic [TW-1:0] out_tag;

  pipelined_radix8_divider #(.WIDTH(W), .TAG_W(TW)) dut (
    .clk(clk), .rst(rst), .split_mode(split_mode), .in_valid(in_valid),
    .in_dividend(in_dividend), .in_divisor(in_divisor), .in_tag(in_tag),
    .out_valid(out_valid), .out_quotient(out_quotient), .out_remainder(out_remainder),
    .out_tag(out_tag), .out_div_by_zero(out_div_by_zero));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int issued = 0, received = 0;
  logic [W-1:0] exp_q [256];
  logic [W-1:0] exp_r [256];
  logic         exp_z [256];
  int           exp_c [256];
  logic [TW-1:0] next_tag = '0;
  logic [TW-1:0] want_tag = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      string rq;
      int lat;
      rq  = split_mode ? "R2" : "R1";
      lat = split_mode ? 11 : 6;
      received++;
      chk(out_tag == want_tag, "R5 tag order", 64'(out_tag), 64'(want_tag));
      if (exp_z[out_tag]) begin
        chk(out_quotient == '1, "R6 quotient", 64'(out_quotient), 64'hFFFFFFFF);
        chk(out_remainder == exp_r[out_tag], "R6 remainder", 64'(out_remainder), 64'(exp_r[out_tag]));
        chk(out_div_by_zero, "R6 flag set", 64'(out_div_by_zero), 64'd1);
      end else begin
        chk(out_quotient == exp_q[out_tag], {rq, " quotient"}, 64'(out_quotient), 64'(exp_q[out_tag]));
        chk(out_remainder == exp_r[out_tag], {rq, " remainder"}, 64'(out_remainder), 64'(exp_r[out_tag]));
        chk(!out_div_by_zero, "R6 flag clear", 64'(out_div_by_zero), 64'd0);
      end
      chk(cyc - exp_c[out_tag] == lat, split_mode ? "R4 latency" : "R3 latency",
          64'(cyc - exp_c[out_tag]), 64'(lat));
      want_tag = want_tag + 1'b1;
    end
  end

  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    in_valid    = 1'b1;
    in_dividend = a;
    in_divisor  = b;
    in_tag      = next_tag;
    exp_z[next_tag] = (b == '0);
    exp_q[next_tag] = (b == '0) ? '1 : a / b;
    exp_r[next_tag] = (b == '0) ? a : a % b;
    exp_c[next_tag] = cyc;
    next_tag = next_tag + 1'b1;
    issued++;
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0;
    repeat (16) @(negedge clk);
    chk(received == issued, "R5 result count", 64'(received), 64'(issued));
  endtask

  task automatic run_mode(input logic m);
    split_mode = m;
    issue(32'd100, 32'd7);
    issue(32'd5, 32'd9);
    issue(32'hFFFFFFFF, 32'd1);
    issue(32'hFFFFFFFF, 32'hFFFFFFFF);
    issue(32'hFFFFFFFE, 32'hFFFFFFFF);
    issue(32'hFFFFFFFF, 32'd7);
    issue(32'h80000000, 32'h80000001);
    issue(32'd0, 32'd3);
    issue(32'd12345, 32'd0);
    issue(32'hFFFFFFFF, 32'd0);
    issue(32'd0, 32'd0);
    for (int a = 0; a < 64; a++)
      for (int b = 0; b < 16; b++)
        issue(W'(a), W'(b));
    for (int n = 0; n < 600; n++) begin
      logic [W-1:0] a, b;
      a = $urandom;
      b = $urandom >> ($urandom % 32);
      issue(a, b);
    end
    drain();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    in_valid = 1'b1;
    in_divisor = 32'd3;
    repeat (4) @(negedge clk);
    chk(!out_valid, "R7 valid low in reset", 64'(out_valid), 64'd0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid, "R7 valid low after reset", 64'(out_valid), 64'd0);
    run_mode(1'b0);
    run_mode(1'b1);
    run_mode(1'b0);
    finish_run();
  end
endmodule